// File: doc/BRIEF.md
# Segmented Current-Steering DAC Decoder with Rotating Calibration

This block is the digital front of a 14-bit segmented current-steering DAC whose unit sources are recalibrated in the background. On each conversion strobe it splits the input code into three fields. The top seven bits become a thermometer count across 128 large unit sources. The middle five bits become a thermometer count across the 31 equal fine cells of one subdivided source. The bottom two bits drive the two smallest fine currents directly.

A calibration scheduler runs beside the decoder. One large source is always parked, which means it is removed from the output while it is calibrated or waiting. The 127 thermometer outputs are laid onto the remaining 127 sources in physical order, skipping the parked one. Of the two subdivided sources, one is active and the other is a spare that is out of the output. The schedule moves the parked slot through every large source in turn and then gives each subdivided source one calibration slot. At the end of each subdivided slot the active and spare roles swap.

A mode input selects the slower conversion rate or the doubled rate. At the doubled rate every slot lasts twice as many conversions, so the rate at which a full calibration round repeats stays the same.

Top module: `dacseg_top`

## Requirements
- R1: While reset is asserted and after it is released, until the first strobe: every source output is off, the fine and LSB outputs are 0, large source 0 is marked parked, subdivided source 0 is active, and the fine-calibration flag is 0.
- R2: After a strobe with coarse value m = code[13:7], exactly m large sources are on. These are the first m unparked sources, counted upward from index 0 and skipping the parked index.
- R3: The parked-source vector always has exactly one bit set, and that source is never on.
- R4: After a strobe, the fine outputs carry a thermometer code of code[6:2]: bits 0 to code[6:2]-1 are 1 and all other bits are 0.
- R5: After a strobe, the two LSB outputs equal code[1:0].
- R6: In the slow mode (fast_mode=0), large source k is parked for the 8 conversions numbered 8k to 8k+7 of each round. The next two slots last 16 conversions each, so one round is 1056 conversions. During those two slots source 127 stays parked and the fine-calibration flag is 1. In every other slot the flag is 0.
- R7: The active subdivided source index (fine_bank_o) toggles exactly at the end of each 16-conversion (slow) or 32-conversion (fast) subdivided slot, and at no other time.
- R8: In the fast mode (fast_mode=1), every slot length doubles: 16 conversions per large source and 32 per subdivided source, so one round is 2112 conversions.
- R9: A cycle without a strobe changes no output and does not advance the schedule.
- R10: The outputs for a conversion use the calibration assignment that was in force at that strobe. The assignment changes only at strobe edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en | input | 1 | Conversion strobe, one cycle per conversion |
| fast_mode | input | 1 | 1 selects doubled rate and doubled slot lengths |
| code_i | input | 14 | Input sample code |
| src_on_o | output | 128 | Per large source: 1 steers it to the positive output |
| src_park_o | output | 128 | One-hot: large source currently parked for calibration |
| fine_on_o | output | 31 | Thermometer select of fine cells in the active subdivided source |
| lsb_on_o | output | 2 | Direct select of the two smallest fine currents |
| fine_bank_o | output | 1 | Index of the active subdivided source; the other one is the spare |
| cal_fine_o | output | 1 | 1 while the spare subdivided source is in its calibration slot |

## Verification
The assertions assume that fast_mode is changed only under reset or between whole slots. If it changes in the middle of a slot, the slot length changes with it. The assertions also assume that conv_en is low during reset. The stimulus holds the mode fixed for each run and changes it only while reset is asserted. The strobe is driven on the falling edge and held low during reset. The stimulus covers whole calibration rounds in both modes, which includes every swap of the subdivided roles. It also inserts idle cycles in the middle of a slot.

// File: rtl/dacseg_pkg.sv
package dacseg_pkg;
    // Which kind of calibration slot the scheduler is in.
    typedef enum logic {
        SLOT_COARSE = 1'b0,
        SLOT_FINE   = 1'b1
    } slot_kind_e;
endpackage

// File: rtl/dacseg_sched.sv
module dacseg_sched
    import dacseg_pkg::*;
#(
    parameter int NBIG      = 128,
    parameter int BIG_SLOT  = 8,
    parameter int FINE_SLOT = 16,
    parameter int IDX_W     = $clog2(NBIG + 2),
    parameter int CNT_W     = $clog2(2 * FINE_SLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             fast,
    output logic [IDX_W-1:0] park_idx,
    output slot_kind_e       kind,
    output logic             bank
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBIG + 1);
    localparam logic [IDX_W-1:0] TOP_BIG  = IDX_W'(NBIG - 1);
    localparam logic [CNT_W:0]   LEN_BS   = (CNT_W+1)'(BIG_SLOT);
    localparam logic [CNT_W:0]   LEN_BF   = (CNT_W+1)'(2 * BIG_SLOT);
    localparam logic [CNT_W:0]   LEN_FS   = (CNT_W+1)'(FINE_SLOT);
    localparam logic [CNT_W:0]   LEN_FF   = (CNT_W+1)'(2 * FINE_SLOT);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             bank;
    } sched_t;

    sched_t     s_d, s_q;
    slot_kind_e kind_w;
    logic [CNT_W:0] len_w;
    logic       slot_end;

    always_comb begin
        kind_w   = (s_q.idx >= IDX_W'(NBIG)) ? SLOT_FINE : SLOT_COARSE;
        if (kind_w == SLOT_FINE) len_w = fast ? LEN_FF : LEN_FS;
        else                     len_w = fast ? LEN_BF : LEN_BS;
        slot_end = ({1'b0, s_q.cnt} >= (len_w - 1'b1));
        s_d      = s_q;
        if (adv) begin
            if (slot_end) begin
                s_d.cnt = '0;
                if (kind_w == SLOT_FINE) s_d.bank = ~s_q.bank;
                s_d.idx = (s_q.idx == LAST_IDX) ? '0 : s_q.idx + 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign kind     = kind_w;
    assign bank     = s_q.bank;
    assign park_idx = (kind_w == SLOT_FINE) ? TOP_BIG : s_q.idx;

    // The slot counter never runs past the longest slot (R8).
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, s_q.cnt} < LEN_FF);
    // Schedule frozen without a strobe (R9).
    assert_sched_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(s_q));
    // Subdivided roles swap only when leaving a fine slot (R7).
    assert_swap_only_fine_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_w == SLOT_COARSE) |=> $stable(s_q.bank));
endmodule

// File: rtl/dacseg_decode.sv
module dacseg_decode #(
    parameter int MSB_W = 7,
    parameter int MID_W = 5,
    parameter int LSB_W = 2,
    parameter int IDX_W = 8,
    localparam int CODE_W = MSB_W + MID_W + LSB_W,
    localparam int NBIG   = 1 << MSB_W,
    localparam int NFINE  = (1 << MID_W) - 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [IDX_W-1:0]  park_idx,
    output logic [NBIG-1:0]   big_on,
    output logic [NFINE-1:0]  fine_on,
    output logic [LSB_W-1:0]  lsb_on
);
    logic [MSB_W-1:0] coarse;
    logic [MID_W-1:0] mid;
    logic [IDX_W-1:0] coarse_w;

    assign coarse   = code[CODE_W-1 -: MSB_W];
    assign mid      = code[LSB_W +: MID_W];
    assign lsb_on   = code[LSB_W-1:0];
    assign coarse_w = IDX_W'(coarse);

    // Below the parked source thermometer bit p lands on source p;
    // above it, bit p-1 lands on source p; the parked source is dark.
    for (genvar p = 0; p < NBIG; p++) begin : g_big
        localparam logic [IDX_W-1:0] P = IDX_W'(p);
        always_comb begin
            if (P < park_idx)      big_on[p] = (P < coarse_w);
            else if (P > park_idx) big_on[p] = (P <= coarse_w);
            else                   big_on[p] = 1'b0;
        end
    end

    for (genvar k = 0; k < NFINE; k++) begin : g_fine
        localparam logic [MID_W-1:0] K = MID_W'(k);
        assign fine_on[k] = (K < mid);
    end
endmodule

// File: rtl/dacseg_top.sv
module dacseg_top
    import dacseg_pkg::*;
#(
    parameter int MSB_W     = 7,
    parameter int MID_W     = 5,
    parameter int LSB_W     = 2,
    parameter int BIG_SLOT  = 8,
    parameter int FINE_SLOT = 16,
    localparam int CODE_W = MSB_W + MID_W + LSB_W,
    localparam int NBIG   = 1 << MSB_W,
    localparam int NFINE  = (1 << MID_W) - 1,
    localparam int IDX_W  = $clog2(NBIG + 2),
    localparam int CNT_W  = $clog2(2 * FINE_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_en,
    input  logic              fast_mode,
    input  logic [CODE_W-1:0] code_i,
    output logic [NBIG-1:0]   src_on_o,
    output logic [NBIG-1:0]   src_park_o,
    output logic [NFINE-1:0]  fine_on_o,
    output logic [LSB_W-1:0]  lsb_on_o,
    output logic              fine_bank_o,
    output logic              cal_fine_o
);
    typedef struct packed {
        logic [NBIG-1:0]  on;
        logic [NBIG-1:0]  park;
        logic [NFINE-1:0] fine;
        logic [LSB_W-1:0] lsb;
        logic             bank;
        logic             calf;
    } out_t;

    localparam out_t OUT_RST = '{on: '0, park: NBIG'(1), fine: '0,
                                 lsb: '0, bank: 1'b0, calf: 1'b0};

    logic [IDX_W-1:0] park_idx;
    slot_kind_e       kind;
    logic             bank;
    logic [NBIG-1:0]  dec_on;
    logic [NFINE-1:0] dec_fine;
    logic [LSB_W-1:0] dec_lsb;
    out_t             o_d, o_q;

    dacseg_sched #(
        .NBIG(NBIG), .BIG_SLOT(BIG_SLOT), .FINE_SLOT(FINE_SLOT),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .adv(conv_en), .fast(fast_mode),
        .park_idx(park_idx), .kind(kind), .bank(bank)
    );

    dacseg_decode #(
        .MSB_W(MSB_W), .MID_W(MID_W), .LSB_W(LSB_W), .IDX_W(IDX_W)
    ) u_dec (
        .code(code_i), .park_idx(park_idx),
        .big_on(dec_on), .fine_on(dec_fine), .lsb_on(dec_lsb)
    );

    always_comb begin
        o_d = o_q;
        if (conv_en) begin
            o_d.on   = dec_on;
            o_d.park = NBIG'(1) << park_idx;
            o_d.fine = dec_fine;
            o_d.lsb  = dec_lsb;
            o_d.bank = bank;
            o_d.calf = (kind == SLOT_FINE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= OUT_RST;
        else        o_q <= o_d;
    end

    assign src_on_o    = o_q.on;
    assign src_park_o  = o_q.park;
    assign fine_on_o   = o_q.fine;
    assign lsb_on_o    = o_q.lsb;
    assign fine_bank_o = o_q.bank;
    assign cal_fine_o  = o_q.calf;

    assert_park_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_park_o) == 1);
    assert_park_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_on_o & src_park_o) == '0);
    assert_coarse_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |=> $countones(src_on_o) == int'($past(code_i[CODE_W-1 -: MSB_W])));
    assert_fine_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |=> $countones(fine_on_o) == int'($past(code_i[LSB_W +: MID_W])));
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> $stable(o_q));
    assert_fine_park_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fine_o |-> src_park_o[NBIG-1]);
endmodule

// File: tb/sim_dacseg_top.sv
module sim_dacseg_top;
    localparam int NB = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_en = 1'b0;
    logic          fast_mode = 1'b0;
    logic [13:0]   code_i = '0;
    logic [127:0]  src_on_o, src_park_o;
    logic [30:0]   fine_on_o;
    logic [1:0]    lsb_on_o;
    logic          fine_bank_o, cal_fine_o;

    int n_chk = 0;
    int n_bad = 0;
    int conv_n = 0;
    logic [13:0] last_code = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dacseg_top u0 (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .fast_mode(fast_mode),
        .code_i(code_i), .src_on_o(src_on_o), .src_park_o(src_park_o),
        .fine_on_o(fine_on_o), .lsb_on_o(lsb_on_o),
        .fine_bank_o(fine_bank_o), .cal_fine_o(cal_fine_o)
    );

    // Stimulus table: coarse / mid / lsb corners and mixed codes.
    localparam logic [13:0] VEC [16] = '{
        14'h0000, 14'h3FFF, 14'h0080, 14'h3F80, 14'h007C, 14'h0003,
        14'h0001, 14'h2000, 14'h1FFF, 14'h0004, 14'h3F7F, 14'h1555,
        14'h2AAA, 14'h0F0F, 14'h00FF, 14'h3E01
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected calibration state for conversion number n.
    task automatic model(input int n, input bit fast,
                         output int park, output bit bnk, output bit calf);
        int L, S, R, pos, sw;
        L = fast ? 16 : 8;
        S = fast ? 32 : 16;
        R = 128 * L + 2 * S;
        pos = n % R;
        sw = 2 * (n / R);
        if (pos < 128 * L) begin
            park = pos / L;
            calf = 0;
        end else begin
            park = 127;
            calf = 1;
            if (pos - 128 * L >= S) sw++;
        end
        bnk = sw[0];
    endtask

    task automatic check_outputs(input logic [13:0] c, input int n, input bit fast);
        int park, m, mid, j;
        bit bnk, calf;
        logic [127:0] e_on, e_park;
        logic [30:0] e_fine;
        model(n, fast, park, bnk, calf);
        m = int'(c[13:7]);
        mid = int'(c[6:2]);
        e_on = '0;
        j = 0;
        for (int p = 0; p < NB; p++) begin
            if (p != park) begin
                e_on[p] = (j < m);
                j++;
            end
        end
        e_park = '0;
        e_park[park] = 1'b1;
        e_fine = '0;
        for (int k = 0; k < 31; k++) e_fine[k] = (k < mid);
        chk(src_on_o == e_on, "R2", "coarse map", src_on_o, e_on);
        chk(src_park_o == e_park, fast ? "R8" : "R6", "parked source", src_park_o, e_park);
        chk((src_on_o & src_park_o) == '0, "R3", "parked source driven",
            src_on_o & src_park_o, '0);
        chk(fine_on_o == e_fine, "R4", "fine thermometer", 128'(fine_on_o), 128'(e_fine));
        chk(lsb_on_o == c[1:0], "R5", "lsb", 128'(lsb_on_o), 128'(c[1:0]));
        chk(fine_bank_o == bnk, "R7", "active bank", 128'(fine_bank_o), 128'(bnk));
        chk(cal_fine_o == calf, fast ? "R8" : "R6", "fine cal flag", 128'(cal_fine_o), 128'(calf));
    endtask

    // One cycle: drive at falling edge, sample at next falling edge (R10).
    task automatic convert(input logic [13:0] c);
        code_i = c;
        conv_en = 1'b1;
        @(negedge clk);
        conv_en = 1'b0;
        check_outputs(c, conv_n, fast_mode);
        last_code = c;
        conv_n++;
    endtask

    task automatic do_reset(input bit fast);
        conv_en = 1'b0;
        rst_n = 1'b0;
        fast_mode = fast;
        repeat (3) @(negedge clk);
        chk(src_on_o == '0 && fine_on_o == '0 && lsb_on_o == '0, "R1",
            "outputs in reset", src_on_o, '0);
        chk(src_park_o == 128'd1 && !fine_bank_o && !cal_fine_o, "R1",
            "cal state in reset", src_park_o, 128'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(src_park_o == 128'd1 && src_on_o == '0, "R1", "after release",
            src_park_o, 128'd1);
        conv_n = 0;
    endtask

    function automatic logic [13:0] gen_code(input int i);
        return 14'((i * 40503 + 977) ^ (i >> 3));
    endfunction

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        // Table walk (R2, R3, R4, R5, R6).
        foreach (VEC[i]) convert(VEC[i]);
        // Idle cycles inside a slot: nothing moves (R9).
        for (int i = 0; i < 5; i++) begin
            code_i = gen_code(i + 7);
            @(negedge clk);
            check_outputs(last_code, conv_n - 1, 1'b0);
        end
        // Slow mode: two full rounds, all slot edges and bank swaps (R6, R7).
        while (conv_n < 2 * 1056 + 20) convert(gen_code(conv_n));
        // Fast mode: two full rounds with doubled slots (R8).
        do_reset(1'b1);
        convert(14'h3FFF);
        convert(14'h0000);
        while (conv_n < 2 * 2112 + 10) begin
            convert(gen_code(conv_n + 3));
            if (conv_n == 1000) begin
                @(negedge clk);
                check_outputs(last_code, conv_n - 1, 1'b1);
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule